// File: doc/BRIEF.md
# Two-Bit Branch History Predictor

This block holds a direct-mapped table of small saturating counters that record how conditional branches behaved in the past. During fetch, a lookup port takes the instruction address, selects one counter with a few low address bits (no tag, so branches whose addresses share those bits share a counter), and returns a taken or not-taken guess in the same cycle. That guess is held inside the block for the following cycle.

In the next cycle the branch sits in decode. The block compares the two source operands of the branch-if-equal with a bitwise XOR followed by an OR reduction, which is far shallower than an adder. It reports the real outcome, raises a misprediction flag when the outcome disagrees with the held guess, and requests a flush of the fetch/decode pipeline register. At the clock edge that closes the decode cycle, the resolved outcome is written back into the counter that produced the guess. Because of this, a wrong guess costs exactly one fetch slot.

A parameter sets the counter width. With one bit, each entry repeats the branch's last outcome. With two bits, each entry has hysteresis, so a single surprise does not reverse a strongly held guess.

Top module: `brhist_predictor`

## Requirements
- R1: After reset every entry predicts not-taken; in 2-bit mode every entry holds value 1 (weakly not-taken), so one taken outcome makes that entry predict taken.
- R2: The entry is selected by lk_pc[IDX_W+ALIGN-1:ALIGN] only, with no tag; two addresses equal in those bits share one entry.
- R3: lk_taken reflects the addressed entry in the same cycle as lk_pc, combinationally: the top counter bit, where 1 means taken.
- R4: In a cycle with id_br_valid high, res_taken is 1 exactly when id_opa equals id_opb, evaluated in that same cycle.
- R5: With HIST_W=1 an entry stores the last resolved outcome (1 = taken) and predicts it.
- R6: With HIST_W=2 an entry is a counter 0..3 that steps up on a taken outcome and down on a not-taken outcome, saturating at 3 and 0; it predicts taken when the value is 2 or 3.
- R7: In 2-bit mode an entry at 3 or 0 changes its prediction only after two consecutive mispredicted outcomes.
- R8: mispredict and flush_ifid are high exactly when id_br_valid is high and res_taken differs from the prediction captured at the last clock edge on which lk_valid was high; both are low whenever id_br_valid is low.
- R9: The resolved outcome updates the entry at the clock edge that ends the id_br_valid cycle; a lookup of that same entry during that cycle returns the value before the update.
- R10: The table does not change in cycles with id_br_valid low, whatever lk_valid and lk_pc do.
- R11: For a branch resolved as taken nine times and then not taken once, repeated, once warm the 2-bit mode mispredicts once per ten and the 1-bit mode twice per ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch-stage lookup request; captures the prediction for the next cycle |
| lk_pc | input | PC_W | Instruction address of the lookup |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| id_br_valid | input | 1 | A branch-if-equal is being resolved in decode this cycle |
| id_opa | input | DATA_W | First source operand of the branch |
| id_opb | input | DATA_W | Second source operand of the branch |
| res_taken | output | 1 | Resolved outcome, 1 = operands equal |
| mispredict | output | 1 | Resolved outcome differs from the held prediction |
| flush_ifid | output | 1 | Request to squash the fetch/decode pipeline register |

## Verification
A counter that holds a wrong value shows up at the ports only when that entry is next looked up. It then appears as a wrong lk_taken in the same cycle and as a wrong mispredict in the cycle after. A fault in the saturation or hysteresis logic therefore stays hidden until a branch runs long enough in one direction and then reverses. For this reason the directed cases drive counters into both saturated ends before the reversal. The random traffic concentrates on a few aliasing addresses, so that lookups often land on recently updated entries. Same-cycle lookup during an update catches a design that forwards the new value too early.

// File: rtl/brhist_pkg.sv
package brhist_pkg;

  // Counter encodings for the two-bit mode.
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr2_e;

  // Reset value of a counter of width w: the highest value that still
  // predicts not-taken.
  function automatic int unsigned ctr_reset_val(input int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/brhist_ctr.sv
module brhist_ctr #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] st_o
);
  localparam logic [HIST_W-1:0] MAXV = '1;
  localparam logic [HIST_W-1:0] RSTV = HIST_W'(brhist_pkg::ctr_reset_val(HIST_W));

  logic [HIST_W-1:0] st_q, st_d;

  // next state: saturating step, held unless enabled
  always_comb begin
    st_d = st_q;
    if (upd_en) begin
      if (upd_taken && (st_q != MAXV)) begin
        st_d = st_q + 1'b1;
      end else if (!upd_taken && (st_q != '0)) begin
        st_d = st_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RSTV;
    end else if (upd_en) begin
      st_q <= st_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/brhist_table.sv
module brhist_table #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_pred,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int unsigned NENT = 1 << IDX_W;

  logic [NENT-1:0] pred_bits;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic              ent_en;
    logic [HIST_W-1:0] ent_st;

    assign ent_en = upd_en && (upd_idx == IDX_W'(g));

    brhist_ctr #(.HIST_W(HIST_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (ent_en),
      .upd_taken(upd_taken),
      .st_o     (ent_st)
    );

    assign pred_bits[g] = ent_st[HIST_W-1];
  end

  // read port returns the registered value, so a same-cycle update is not seen
  assign rd_pred = pred_bits[rd_idx];
endmodule

// File: rtl/brhist_eqres.sv
module brhist_eqres #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              equal
);
  localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] diff;
  logic [LANES-1:0] lane_ne;

  // bitwise difference, padded with zeros up to whole lanes
  assign diff = PAD_W'(opa ^ opb);

  // two-level OR reduction: per lane, then across lanes
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ne[l] = |diff[l*LANE_W +: LANE_W];
  end

  assign equal = ~|lane_ne;
endmodule

// File: rtl/brhist_track.sv
module brhist_track #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_pred,
  input  logic             id_br_valid,
  input  logic             id_equal,
  output logic             upd_en,
  output logic [IDX_W-1:0] upd_idx,
  output logic             upd_taken,
  output logic             miss
);
  logic             held_pred_q, held_pred_d;
  logic [IDX_W-1:0] held_idx_q, held_idx_d;

  always_comb begin
    held_pred_d = held_pred_q;
    held_idx_d  = held_idx_q;
    if (lk_valid) begin
      held_pred_d = lk_pred;
      held_idx_d  = lk_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_pred_q <= 1'b0;
      held_idx_q  <= '0;
    end else if (lk_valid) begin
      held_pred_q <= held_pred_d;
      held_idx_q  <= held_idx_d;
    end
  end

  assign upd_en    = id_br_valid;
  assign upd_idx   = held_idx_q;
  assign upd_taken = id_equal;
  assign miss      = id_br_valid && (id_equal != held_pred_q);
endmodule

// File: rtl/brhist_predictor.sv
module brhist_predictor #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ALIGN  = 2,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  input  logic              id_br_valid,
  input  logic [DATA_W-1:0] id_opa,
  input  logic [DATA_W-1:0] id_opb,
  output logic              res_taken,
  output logic              mispredict,
  output logic              flush_ifid
);
  localparam int unsigned IDX_LO = ALIGN;
  localparam int unsigned IDX_HI = ALIGN + IDX_W - 1;

  if ((HIST_W < 1) || (HIST_W > 2)) begin : g_bad_hist
    $error("HIST_W must be 1 or 2");
  end

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_en;
  logic             upd_taken;
  logic             id_equal;
  logic             miss;
  logic             unused_pc_bits;

  assign lk_idx         = lk_pc[IDX_HI:IDX_LO];
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0]};

  brhist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_pred  (lk_taken),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_taken(upd_taken)
  );

  brhist_eqres #(.DATA_W(DATA_W)) eq_i (
    .opa  (id_opa),
    .opb  (id_opb),
    .equal(id_equal)
  );

  brhist_track #(.IDX_W(IDX_W)) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_idx     (lk_idx),
    .lk_pred    (lk_taken),
    .id_br_valid(id_br_valid),
    .id_equal   (id_equal),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_taken  (upd_taken),
    .miss       (miss)
  );

  assign res_taken  = id_equal;
  assign mispredict = miss;
  assign flush_ifid = miss;
endmodule

// File: rtl/brhist_chk.sv
module brhist_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              lk_taken,
  input logic              id_br_valid,
  input logic [DATA_W-1:0] id_opa,
  input logic [DATA_W-1:0] id_opb,
  input logic              res_taken,
  input logic              mispredict,
  input logic              flush_ifid,
  input logic [IDX_W-1:0]  upd_idx
);
  // R4
  eq_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_br_valid |-> (res_taken == (id_opa == id_opb)));

  // R8
  no_branch_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_br_valid |-> (!mispredict && !flush_ifid));

  // R8
  miss_vs_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid) && id_br_valid) |-> (mispredict == (res_taken != $past(lk_taken))));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!id_br_valid) && $past(lk_valid) && lk_valid && $stable(lk_idx))
      |-> $stable(lk_taken));

  // R9
  correct_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(id_br_valid && !mispredict) && lk_valid && (lk_idx == $past(upd_idx)))
      |-> (lk_taken == $past(res_taken)));

  if (HIST_W == 1) begin : g_one
    // R5
    last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(id_br_valid) && lk_valid && (lk_idx == $past(upd_idx)))
        |-> (lk_taken == $past(res_taken)));
  end
endmodule

bind brhist_predictor brhist_chk #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W),
  .HIST_W(HIST_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_idx     (lk_idx),
  .lk_taken   (lk_taken),
  .id_br_valid(id_br_valid),
  .id_opa     (id_opa),
  .id_opb     (id_opb),
  .res_taken  (res_taken),
  .mispredict (mispredict),
  .flush_ifid (flush_ifid),
  .upd_idx    (upd_idx)
);

// File: tb/brhist_predictor_tb_top.sv
`timescale 1ns/1ps
module brhist_predictor_tb_top;
  localparam int IDX_W = 6;
  localparam int ALIGN = 2;
  localparam int NENT  = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        id_br_valid;
  logic [31:0] id_opa, id_opb;
  logic        lk2, res2, miss2, fl2;
  logic        lk1, res1, miss1, fl1;

  int  m2 [NENT];
  int  m1 [NENT];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  brhist_predictor #(.HIST_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk2),
    .id_br_valid(id_br_valid), .id_opa(id_opa), .id_opb(id_opb),
    .res_taken(res2), .mispredict(miss2), .flush_ifid(fl2));

  brhist_predictor #(.HIST_W(1)) dut_1b_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk1),
    .id_br_valid(id_br_valid), .id_opa(id_opa), .id_opb(id_opb),
    .res_taken(res1), .mispredict(miss1), .flush_ifid(fl1));

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[IDX_W+ALIGN-1:ALIGN]);
  endfunction

  function automatic int step(input int c, input bit t, input int maxv);
    if (t) return (c < maxv) ? c + 1 : c;
    return (c > 0) ? c - 1 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // lookup only, checks both modes against the models (R3, R10)
  task automatic lookup_only(input logic [31:0] pc, input string req);
    int i = idx_of(pc);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; id_br_valid = 1'b0;
    #1;
    chk(lk2 == (m2[i] >= 2), req, lk2, m2[i] >= 2);
    chk(lk1 == (m1[i] >= 1), req, lk1, m1[i] >= 1);
  endtask

  // lookup cycle followed by resolve cycle
  task automatic branch(input logic [31:0] pc, input bit take, input bit same_lk,
                        output bit mo2, output bit mo1);
    int i = idx_of(pc);
    bit p2 = (m2[i] >= 2);
    bit p1 = (m1[i] >= 1);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; id_br_valid = 1'b0;
    id_opa = $urandom; id_opb = $urandom;
    #1;
    chk(lk2 == p2, "R3/R6 lookup 2-bit", lk2, p2);
    chk(lk1 == p1, "R3/R5 lookup 1-bit", lk1, p1);
    @(negedge clk);
    id_br_valid = 1'b1;
    id_opa = $urandom;
    id_opb = take ? id_opa : (id_opa ^ (32'h1 << ($urandom % 32)));
    lk_valid = same_lk; lk_pc = pc;
    #1;
    chk(res2 == take, "R4 resolve", res2, take);
    chk(res1 == take, "R4 resolve 1-bit", res1, take);
    chk(miss2 == (take != p2), "R8 mispredict 2-bit", miss2, take != p2);
    chk(fl2 == (take != p2), "R8 flush 2-bit", fl2, take != p2);
    chk(miss1 == (take != p1), "R8 mispredict 1-bit", miss1, take != p1);
    if (same_lk) begin
      chk(lk2 == p2, "R9 same-cycle old value", lk2, p2);
      chk(lk1 == p1, "R9 same-cycle old value 1-bit", lk1, p1);
    end
    mo2 = miss2; mo1 = miss1;
    m2[i] = step(m2[i], take, 3);
    m1[i] = step(m1[i], take, 1);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      lk_valid = $urandom % 2; lk_pc = $urandom; id_br_valid = 1'b0;
      id_opa = $urandom; id_opb = id_opa;
      #1;
      chk(!miss2 && !fl2 && !miss1, "R8 quiet without branch", miss2, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    bit a2, a1;
    int c2, c1;
    void'($urandom(32'd1234));
    for (int i = 0; i < NENT; i++) begin m2[i] = 1; m1[i] = 0; end
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; id_br_valid = 1'b0;
    id_opa = '0; id_opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    lookup_only(32'h0000_1000, "R1 reset predicts not-taken");
    lookup_only(32'h0000_10FC, "R1 reset predicts not-taken");
    branch(32'h0000_1000, 1'b1, 1'b0, a2, a1);
    chk(a2 == 1'b1, "R1 first taken mispredicted", a2, 1);
    lookup_only(32'h0000_1000, "R1 one taken flips weak entry");
    chk(lk2 == 1'b1, "R1 weak not-taken flips after one taken", lk2, 1);

    // R6/R7: saturate high, then reverse
    for (int k = 0; k < 4; k++) branch(32'h0000_1004, 1'b1, 1'b0, a2, a1);
    branch(32'h0000_1004, 1'b0, 1'b0, a2, a1);
    chk(a2 == 1'b1, "R7 first reversal mispredicted", a2, 1);
    lookup_only(32'h0000_1004, "R7 lookup");
    chk(lk2 == 1'b1, "R7 strong taken survives one miss", lk2, 1);
    chk(lk1 == 1'b0, "R5 1-bit follows last outcome", lk1, 0);
    branch(32'h0000_1004, 1'b0, 1'b0, a2, a1);
    lookup_only(32'h0000_1004, "R7 lookup");
    chk(lk2 == 1'b0, "R7 flips after two misses", lk2, 0);
    // saturate low, then reverse
    for (int k = 0; k < 3; k++) branch(32'h0000_1004, 1'b0, 1'b0, a2, a1);
    branch(32'h0000_1004, 1'b1, 1'b1, a2, a1);
    lookup_only(32'h0000_1004, "R6 lookup");
    chk(lk2 == 1'b0, "R6 strong not-taken survives one miss", lk2, 0);

    // R2: aliasing addresses share an entry
    branch(32'h0000_1008, 1'b1, 1'b0, a2, a1);
    branch(32'h0000_1008, 1'b1, 1'b0, a2, a1);
    lookup_only(32'h0000_1108, "R2 alias lookup");
    chk(lk2 == 1'b1, "R2 alias shares entry", lk2, 1);

    // R10: idle cycles leave the table alone
    idle(6);
    lookup_only(32'h0000_1008, "R10 table unchanged after idle");

    // R11: loop branch, three visits of nine taken and one exit
    for (int v = 0; v < 3; v++) begin
      c2 = 0; c1 = 0;
      for (int k = 0; k < 10; k++) begin
        branch(32'h0000_2010, k < 9, 1'b0, a2, a1);
        c2 += a2; c1 += a1;
      end
      if (v > 0) begin
        chk(c2 == 1, "R11 2-bit one miss per visit", c2, 1);
        chk(c1 == 2, "R11 1-bit two misses per visit", c1, 2);
      end
    end

    // random traffic on aliasing addresses
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pc;
      pc = 32'h0000_3000 + (($urandom % 12) * 4) + (($urandom % 2) * 32'h100);
      branch(pc, $urandom % 2, $urandom % 2, a2, a1);
      if ($urandom % 4 == 0) idle($urandom % 3);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule